// File: doc/BRIEF.md
# Address Region Attribute Unit

This block keeps eight software-programmed windows of the 32-bit physical address space and tells the memory pipeline which caching and ordering policy applies to an address. Software programs the windows one byte at a time. It first writes a register number to an index port, then reads or writes that register's byte at a data port. Each window has a start address and a 4-bit size code spread over three bytes, plus one attribute byte.

A lookup address goes in every cycle. One clock later the block presents the result: a hit flag, the number of the winning window, and the effective attributes (cacheable, write-through, write gathering, weak write ordering, weak locking, local-bus-off). When windows overlap, the lowest-numbered one wins. An address outside every window gets a fixed default policy.

Top module: `arr_attr_unit`

## Requirements
- R1: Writing port 0x22 latches a register number. A write at port 0x23 stores `io_wdata` into the selected register. A read at port 0x23 shows that register's byte on `io_rdata` after the next rising edge. `io_rdata` is 0x00 after every edge that had no data-port read.
- R2: The latched register number changes only when port 0x22 is written, so back-to-back data-port accesses all reach the same register.
- R3: When the latched number is outside 0xC4..0xE3, a data-port write changes no register and a data-port read returns 0x00.
- R4: Reset clears every configuration byte. After reset every lookup misses.
- R5: Window r (0..7) uses registers 0xC4+3r, 0xC5+3r and 0xC6+3r. The first holds start address bits 31..24 and the second holds bits 23..16. The third holds bits 15..12 in its upper nibble and the size code in its lower nibble.
- R6: Size code 0 disables a window. Codes 1..14 give a window of 2^(11+code) bytes (4 KB to 32 MB). Code 15 covers the whole 4 GB space.
- R7: An address hits an enabled window when it equals the start address on every bit at or above the window size. Start-address bits below the window size are ignored.
- R8: When several windows hit, the one with the lowest number is reported along with its attributes.
- R9: On a miss, `lk_hit` is 0, `lk_region` is 0 and `lk_cacheable` is 1. All other attribute outputs are 0.
- R10: Window r's attribute byte is register 0xDC+r. Its bits map to the outputs as follows: bit 1 to weak write ordering, bit 2 to weak locking, bit 3 to write gathering, bit 4 to write-through, and bit 5 to local-bus-off.
- R11: Attribute bit 0 has opposite meanings depending on the window. For windows 0..6, a 1 makes the window uncacheable. For window 7, a 1 makes it cacheable.
- R12: Lookup outputs are registered and reflect the address present before the rising edge. A configuration write takes effect for the lookup sampled at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Port write strobe |
| io_rd | input | 1 | Port read strobe |
| io_addr | input | 8 | Port number (0x22 index, 0x23 data) |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Registered read byte |
| lk_addr | input | 32 | Lookup physical address |
| lk_hit | output | 1 | Address is inside an enabled window |
| lk_region | output | 3 | Winning window number |
| lk_cacheable | output | 1 | Effective cacheable |
| lk_wthru | output | 1 | Write-through |
| lk_wgather | output | 1 | Write gathering |
| lk_wlock | output | 1 | Weak locking |
| lk_worder | output | 1 | Weak write ordering |
| lk_no_lbus | output | 1 | Local-bus signal not asserted |

## Verification
The lookup result and the read byte each appear one rising edge after their inputs. A configuration write becomes visible in the lookup registered on the edge after the write edge. The bench changes inputs on falling edges and samples outputs 1 ns after the rising edge that completes each operation. For the write-to-lookup case it samples on two edges in a row: the first must still show the old policy and the second must show the new one.

// File: rtl/arr_pkg.sv
package arr_pkg;
  localparam int ATTR_BITS = 6;

  typedef struct packed {
    logic no_lbus;
    logic wthru;
    logic wgather;
    logic wlock;
    logic worder;
    logic cacheable;
  } arr_attr_t;

  localparam arr_attr_t MISS_ATTR = '{no_lbus: 1'b0, wthru: 1'b0, wgather: 1'b0,
                                      wlock: 1'b0, worder: 1'b0, cacheable: 1'b1};
endpackage

// File: rtl/arr_cfg_regs.sv
module arr_cfg_regs #(
  parameter int BASE_IDX   = 8'hC4,
  parameter int NUM_BYTES  = 32,
  parameter int INDEX_PORT = 8'h22,
  parameter int DATA_PORT  = 8'h23
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   io_wr,
  input  logic                   io_rd,
  input  logic [7:0]             io_addr,
  input  logic [7:0]             io_wdata,
  output logic [7:0]             io_rdata,
  output logic [NUM_BYTES*8-1:0] cfg_flat
);
  localparam int OFF_W = $clog2(NUM_BYTES);

  logic [7:0]       idx_q;
  logic [7:0]       bytes_q [NUM_BYTES];
  logic             in_range;
  logic [OFF_W-1:0] off;
  logic             idx_wr, data_wr, data_rd;

  assign in_range = (int'(idx_q) >= BASE_IDX) && (int'(idx_q) < BASE_IDX + NUM_BYTES);
  assign off      = OFF_W'(idx_q - 8'(BASE_IDX));
  assign idx_wr   = io_wr && (io_addr == 8'(INDEX_PORT));
  assign data_wr  = io_wr && (io_addr == 8'(DATA_PORT));
  assign data_rd  = io_rd && (io_addr == 8'(DATA_PORT));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      io_rdata <= '0;
      for (int i = 0; i < NUM_BYTES; i++) bytes_q[i] <= '0;
    end else begin
      if (idx_wr) idx_q <= io_wdata;
      if (data_wr && in_range) bytes_q[off] <= io_wdata;
      io_rdata <= (data_rd && in_range) ? bytes_q[off] : 8'h00;
    end
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_flat
    assign cfg_flat[g*8 +: 8] = bytes_q[g];
  end

  assert_reset_clear_R4: assert property (@(posedge clk)
    $past(rst) |-> (cfg_flat == '0));
  assert_oob_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !in_range) |=> $stable(cfg_flat));
  assert_index_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    !idx_wr |=> $stable(idx_q));
  assert_rdata_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !data_rd |=> (io_rdata == 8'h00));
endmodule

// File: rtl/arr_match.sv
module arr_match #(
  parameter int ADDR_W  = 32,
  parameter int PAGE_SH = 12
) (
  input  logic [ADDR_W-PAGE_SH-1:0] start_hi,
  input  logic [3:0]                size_code,
  input  logic [ADDR_W-1:0]         addr,
  output logic                      hit
);
  localparam int HI_W = ADDR_W - PAGE_SH;

  logic [HI_W-1:0] care;
  logic [HI_W-1:0] diff;

  // Code c spans 2^(PAGE_SH-1+c) bytes; address bit (b+PAGE_SH) is compared when b+1 >= c.
  always_comb begin
    for (int b = 0; b < HI_W; b++)
      care[b] = (size_code != 4'hF) && ((b + 1) >= int'(size_code));
  end

  assign diff = (addr[ADDR_W-1:PAGE_SH] ^ start_hi) & care;
  assign hit  = (size_code != 4'h0) && (diff == '0);
endmodule

// File: rtl/arr_select.sv
module arr_select
  import arr_pkg::*;
#(
  parameter int N_REG = 8,
  localparam int IDX_W = $clog2(N_REG)
) (
  input  logic [N_REG-1:0]   hit_vec,
  input  logic [N_REG*8-1:0] attr_flat,
  output logic               any_hit,
  output logic [IDX_W-1:0]   win,
  output arr_attr_t          attr
);
  logic [7:0] ab;

  always_comb begin
    any_hit = 1'b0;
    win     = '0;
    for (int i = N_REG - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        win     = IDX_W'(i);
      end
    end
  end

  assign ab = attr_flat[win*8 +: 8];

  always_comb begin
    if (!any_hit) begin
      attr = MISS_ATTR;
    end else begin
      attr.no_lbus   = ab[5];
      attr.wthru     = ab[4];
      attr.wgather   = ab[3];
      attr.wlock     = ab[2];
      attr.worder    = ab[1];
      // Last window: bit 0 enables caching; all others: bit 0 disables it.
      attr.cacheable = (int'(win) == N_REG - 1) ? ab[0] : ~ab[0];
    end
  end
endmodule

// File: rtl/arr_attr_unit.sv
module arr_attr_unit
  import arr_pkg::*;
#(
  parameter int N_REG      = 8,
  parameter int ADDR_W     = 32,
  parameter int BASE_IDX   = 8'hC4,
  parameter int INDEX_PORT = 8'h22,
  parameter int DATA_PORT  = 8'h23
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_addr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic [31:0] lk_addr,
  output logic        lk_hit,
  output logic [2:0]  lk_region,
  output logic        lk_cacheable,
  output logic        lk_wthru,
  output logic        lk_wgather,
  output logic        lk_wlock,
  output logic        lk_worder,
  output logic        lk_no_lbus
);
  localparam int PAGE_SH   = 12;
  localparam int HI_W      = ADDR_W - PAGE_SH;
  localparam int RGN_BYTES = 3 * N_REG;
  localparam int NUM_BYTES = RGN_BYTES + N_REG;
  localparam int IDX_W     = $clog2(N_REG);

  logic [NUM_BYTES*8-1:0] cfg_flat;
  logic [N_REG-1:0]       hit_vec;
  logic                   any_hit;
  logic [IDX_W-1:0]       win;
  arr_attr_t              attr_c, attr_q;

  arr_cfg_regs #(
    .BASE_IDX(BASE_IDX), .NUM_BYTES(NUM_BYTES),
    .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)
  ) u_cfg (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_flat(cfg_flat)
  );

  for (genvar r = 0; r < N_REG; r++) begin : g_win
    logic [7:0] b0, b1, b2;
    assign b0 = cfg_flat[(3*r)*8 +: 8];
    assign b1 = cfg_flat[(3*r+1)*8 +: 8];
    assign b2 = cfg_flat[(3*r+2)*8 +: 8];
    arr_match #(.ADDR_W(ADDR_W), .PAGE_SH(PAGE_SH)) u_match (
      .start_hi(HI_W'({b0, b1, b2[7:4]})),
      .size_code(b2[3:0]),
      .addr(lk_addr[ADDR_W-1:0]),
      .hit(hit_vec[r])
    );
  end

  arr_select #(.N_REG(N_REG)) u_sel (
    .hit_vec(hit_vec),
    .attr_flat(cfg_flat[NUM_BYTES*8-1:RGN_BYTES*8]),
    .any_hit(any_hit),
    .win(win),
    .attr(attr_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit    <= 1'b0;
      lk_region <= '0;
      attr_q    <= MISS_ATTR;
    end else begin
      lk_hit    <= any_hit;
      lk_region <= 3'(win);
      attr_q    <= attr_c;
    end
  end

  assign lk_cacheable = attr_q.cacheable;
  assign lk_wthru     = attr_q.wthru;
  assign lk_wgather   = attr_q.wgather;
  assign lk_wlock     = attr_q.wlock;
  assign lk_worder    = attr_q.worder;
  assign lk_no_lbus   = attr_q.no_lbus;

  assert_miss_default_R9: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_cacheable && !lk_wthru && !lk_wgather && !lk_wlock &&
                 !lk_worder && !lk_no_lbus && lk_region == 3'd0));
  assert_no_hit_after_reset_R4: assert property (@(posedge clk)
    $past(rst) |=> !lk_hit);
endmodule

// File: tb/arr_attr_unit_tb.sv
module arr_attr_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_addr = 8'h00, io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic [31:0] lk_addr = 32'h0;
  logic        lk_hit;
  logic [2:0]  lk_region;
  logic        lk_cacheable, lk_wthru, lk_wgather, lk_wlock, lk_worder, lk_no_lbus;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  arr_attr_unit u_dut (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .lk_region(lk_region), .lk_cacheable(lk_cacheable), .lk_wthru(lk_wthru),
    .lk_wgather(lk_wgather), .lk_wlock(lk_wlock), .lk_worder(lk_worder),
    .lk_no_lbus(lk_no_lbus)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=50000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // attr vector {no_lbus, wthru, wgather, wlock, worder, cacheable}
  function automatic logic [5:0] ex_attr(input int r, input logic [7:0] a);
    return {a[5], a[4], a[3], a[2], a[1], (r == 7) ? a[0] : ~a[0]};
  endfunction

  task automatic port_wr(input logic [7:0] port, input logic [7:0] d);
    @(negedge clk); io_addr = port; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic data_rd(output logic [7:0] v);
    @(negedge clk); io_addr = 8'h23; io_rd = 1'b1;
    @(posedge clk); #1 v = io_rdata;
    @(negedge clk); io_rd = 1'b0;
  endtask

  task automatic cfg_wr(input logic [7:0] idx, input logic [7:0] d);
    port_wr(8'h22, idx); port_wr(8'h23, d);
  endtask

  task automatic cfg_rd(input logic [7:0] idx, output logic [7:0] v);
    port_wr(8'h22, idx); data_rd(v);
  endtask

  task automatic prog(input int r, input logic [31:0] st, input logic [3:0] code, input logic [7:0] a);
    cfg_wr(8'(8'hC4 + 3*r), st[31:24]);
    cfg_wr(8'(8'hC5 + 3*r), st[23:16]);
    cfg_wr(8'(8'hC6 + 3*r), {st[15:12], code});
    cfg_wr(8'(8'hDC + r), a);
  endtask

  task automatic look(input logic [31:0] addr, input bit eh, input logic [2:0] er,
                      input logic [5:0] ea, input string req);
    logic [5:0] act;
    @(negedge clk); lk_addr = addr;
    @(posedge clk); #1;
    act = {lk_no_lbus, lk_wthru, lk_wgather, lk_wlock, lk_worder, lk_cacheable};
    chk(lk_hit == eh, req, 32'(lk_hit), 32'(eh));
    chk(lk_region == er, req, 32'(lk_region), 32'(er));
    chk(act == ea, req, 32'(act), 32'(ea));
  endtask

  localparam logic [5:0] MISS = 6'b000001;

  task automatic t_reset();
    logic [7:0] v;
    cfg_rd(8'hC4, v); chk(v == 8'h00, "R4 reset byte", 32'(v), 32'h0);
    cfg_rd(8'hE3, v); chk(v == 8'h00, "R4 reset attr", 32'(v), 32'h0);
    look(32'h0000_0000, 1'b0, 3'd0, MISS, "R4 R9 miss after reset");
    look(32'hFFFF_F000, 1'b0, 3'd0, MISS, "R4 R9 miss top");
  endtask

  task automatic t_layout();
    logic [7:0] v;
    prog(0, 32'h1000_0000, 4'd9, 8'h10);
    cfg_rd(8'hC4, v); chk(v == 8'h10, "R1 R5 byte0", 32'(v), 32'h10);
    cfg_rd(8'hC6, v); chk(v == 8'h09, "R1 R5 byte2", 32'(v), 32'h09);
    cfg_rd(8'hDC, v); chk(v == 8'h10, "R1 R10 attr", 32'(v), 32'h10);
    look(32'h100F_FFFF, 1'b1, 3'd0, ex_attr(0, 8'h10), "R5 R6 R10 1MB inside");
    look(32'h1010_0000, 1'b0, 3'd0, MISS, "R6 R9 1MB outside");
  endtask

  task automatic t_lowbits();
    prog(1, 32'h2000_5000, 4'd5, 8'h00);
    look(32'h2000_0000, 1'b1, 3'd1, ex_attr(1, 8'h00), "R7 low start bits ignored");
    look(32'h2000_FFFF, 1'b1, 3'd1, ex_attr(1, 8'h00), "R7 top of 64KB");
    look(32'h2001_0000, 1'b0, 3'd0, MISS, "R7 past 64KB");
  endtask

  task automatic t_sizes();
    prog(2, 32'h3000_0000, 4'd1, 8'h00);
    look(32'h3000_0FFF, 1'b1, 3'd2, ex_attr(2, 8'h00), "R6 code1 inside");
    look(32'h3000_1000, 1'b0, 3'd0, MISS, "R6 code1 outside");
    prog(3, 32'h4200_0000, 4'd14, 8'h00);
    look(32'h43FF_FFFF, 1'b1, 3'd3, ex_attr(3, 8'h00), "R6 code14 top");
    look(32'h4400_0000, 1'b0, 3'd0, MISS, "R6 code14 above");
    look(32'h41FF_FFFF, 1'b0, 3'd0, MISS, "R6 code14 below");
  endtask

  task automatic t_priority();
    prog(4, 32'h1000_0000, 4'd10, 8'h0E);
    look(32'h1000_0000, 1'b1, 3'd0, ex_attr(0, 8'h10), "R8 lower number wins");
    look(32'h1010_0000, 1'b1, 3'd4, ex_attr(4, 8'h0E), "R8 R10 only r4");
  endtask

  task automatic t_timing();
    cfg_wr(8'hD3, 8'h60); cfg_wr(8'hD4, 8'h00); cfg_wr(8'hE1, 8'h00);
    port_wr(8'h22, 8'hD5);
    @(negedge clk); io_addr = 8'h23; io_wdata = 8'h01; io_wr = 1'b1; lk_addr = 32'h6000_0000;
    @(posedge clk); #1;
    chk(lk_hit == 1'b0, "R12 old config on write edge", 32'(lk_hit), 32'h0);
    @(negedge clk); io_wr = 1'b0;
    @(posedge clk); #1;
    chk(lk_hit == 1'b1 && lk_region == 3'd5, "R12 new config next edge",
        {lk_hit, 28'h0, lk_region}, {1'b1, 28'h0, 3'd5});
  endtask

  task automatic t_polarity();
    cfg_wr(8'hE1, 8'h01);
    look(32'h6000_0000, 1'b1, 3'd5, 6'b000000, "R11 r5 bit0 uncached");
    cfg_wr(8'hE1, 8'h21);
    look(32'h6000_0000, 1'b1, 3'd5, 6'b100000, "R10 R11 r5 no local bus");
    prog(7, 32'h5000_0000, 4'd1, 8'h01);
    look(32'h5000_0000, 1'b1, 3'd7, 6'b000001, "R11 r7 bit0 cached");
    cfg_wr(8'hE3, 8'h00);
    look(32'h5000_0000, 1'b1, 3'd7, 6'b000000, "R11 r7 bit0 clear uncached");
  endtask

  task automatic t_full();
    prog(6, 32'h0000_0000, 4'd15, 8'h01);
    look(32'hFFFF_F000, 1'b1, 3'd6, ex_attr(6, 8'h01), "R6 code15 whole space");
    look(32'h1000_0000, 1'b1, 3'd0, ex_attr(0, 8'h10), "R8 r0 over r6");
  endtask

  task automatic t_out_of_range();
    logic [7:0] v;
    cfg_wr(8'hC3, 8'hAA);
    data_rd(v); chk(v == 8'h00, "R3 read below range", 32'(v), 32'h0);
    cfg_wr(8'hE4, 8'h55);
    data_rd(v); chk(v == 8'h00, "R3 read above range", 32'(v), 32'h0);
    cfg_rd(8'hC4, v); chk(v == 8'h10, "R3 neighbour unchanged", 32'(v), 32'h10);
    cfg_rd(8'hE3, v); chk(v == 8'h00, "R3 last attr unchanged", 32'(v), 32'h0);
    look(32'h1000_0000, 1'b1, 3'd0, ex_attr(0, 8'h10), "R3 lookup unchanged");
  endtask

  task automatic t_sticky();
    logic [7:0] v;
    port_wr(8'h22, 8'hDD);
    port_wr(8'h23, 8'h08);
    port_wr(8'h23, 8'h18);
    data_rd(v); chk(v == 8'h18, "R2 repeated write same reg", 32'(v), 32'h18);
    data_rd(v); chk(v == 8'h18, "R2 repeated read same reg", 32'(v), 32'h18);
    look(32'h2000_0000, 1'b1, 3'd1, ex_attr(1, 8'h18), "R2 R10 wthru wgather");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_layout();
    t_lowbits();
    t_sizes();
    t_priority();
    t_timing();
    t_polarity();
    t_full();
    t_out_of_range();
    t_sticky();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule